// File: doc/BRIEF.md
# Slave Idle Handshake Controller

This block answers a system power controller's idle request on behalf of a peripheral. It decides when to acknowledge idle, according to one of three selectable policies. Under force policy it acknowledges at once. Under never policy it holds the acknowledge low. Under smart policy it waits until the peripheral's bus goes quiet. The same state drives an enable for the peripheral's internal clock gate and a wakeup line. The wakeup line tells the power controller that bus traffic wants the peripheral back while it sits idle.

The block also runs a timed soft-reset sequence. A configuration write with the reset bit set drives an internal reset for a fixed number of cycles. A status bit reports whether the reset has finished. The same sequence runs once after the hardware reset is released. The register decoder that produces the configuration fields and the write strobe is outside this block, and so is the clock-gating cell that takes the enable.

Top module: `slave_idle_ctrl`

## Requirements
- R1: With idle policy code 0 (force) or the spare code 3, `idle_ack_o` is 1 on the clock edge after `idle_req_i` is sampled high, whatever `bus_active_i` is.
- R2: With idle policy code 1 (never), `idle_ack_o` is 0 on the edge after that code is sampled.
- R3: With idle policy code 2 (smart), `idle_ack_o` rises on the first edge at which `idle_req_i` is high and `bus_active_i` is low. Once set, it stays set while the request holds.
- R4: `idle_ack_o` is 0 on the edge after `idle_req_i` is sampled low, under every policy.
- R5: A write strobe with data bit 1 asserts `int_rst_o` for exactly RST_CYCLES (default 16) edges, and `reset_done_o` is its inverse. A strobe with data bit 0 changes nothing.
- R6: A new reset write while the sequence is running restarts the full count.
- R7: After the hardware reset is released, the sequence runs once: `int_rst_o` is 1 and `reset_done_o` is 0 for RST_CYCLES edges.
- R8: With autoidle 1, `clk_en_o` follows `bus_active_i`. With autoidle 0, `clk_en_o` is 1, except as R9 gives.
- R9: While `idle_ack_o` is 1 and clock-activity is 0, `clk_en_o` is 0. With clock-activity 1, idle does not gate the clock.
- R10: `wakeup_o` is 1 exactly when wakeup enable, `idle_ack_o` and `bus_active_i` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| idle_req_i | input | 1 | Idle request from power controller |
| bus_active_i | input | 1 | Peripheral bus activity present |
| idle_mode_i | input | 2 | Idle policy: 0 force, 1 never, 2 smart, 3 as force |
| autoidle_i | input | 1 | Gate the clock whenever the bus is inactive |
| clkact_i | input | 1 | Keep the internal clock running while idle |
| wake_en_i | input | 1 | Permit wakeup generation |
| srst_wr_i | input | 1 | Write strobe of the soft-reset field |
| srst_data_i | input | 1 | Data bit written to the soft-reset field |
| idle_ack_o | output | 1 | Idle acknowledge |
| clk_en_o | output | 1 | Enable for the internal clock gate |
| wakeup_o | output | 1 | Wakeup request |
| int_rst_o | output | 1 | Internal reset, active high |
| reset_done_o | output | 1 | Reset complete status |

## Verification
Random request, activity and policy changes are mixed so that smart policy meets both quiet and busy buses. This separates acknowledge-on-quiet from force behaviour and from the sticky hold after acknowledge. Random autoidle, clock-activity and wakeup-enable settings, crossed with acknowledged and unacknowledged states, separate the autoidle gate from the idle gate. Directed cases cover the power-up sequence, a restart in the middle of a sequence, and zero-data writes, so that an early release or a missed restart changes the length of the reset window.

// File: rtl/sidle_pkg.sv
package sidle_pkg;
    typedef enum logic [1:0] {
        IDLE_FORCE = 2'd0,
        IDLE_NEVER = 2'd1,
        IDLE_SMART = 2'd2,
        IDLE_SPARE = 2'd3
    } idle_mode_e;
endpackage

// File: rtl/sidle_ack_fsm.sv
module sidle_ack_fsm
    import sidle_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idle_req_i,
    input  logic       bus_active_i,
    input  idle_mode_e mode_i,
    output logic       ack_o
);
    typedef struct packed {
        logic ack;
    } ack_state_t;

    ack_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!idle_req_i) begin
            st_d.ack = 1'b0;
        end else begin
            unique case (mode_i)
                IDLE_NEVER: st_d.ack = 1'b0;
                // smart: latch once the bus is quiet, hold until request drops
                IDLE_SMART: st_d.ack = st_q.ack | ~bus_active_i;
                default:    st_d.ack = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack_o = st_q.ack;
endmodule

// File: rtl/sidle_rst_seq.sv
module sidle_rst_seq #(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = (RST_CYCLES > 2) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD = CW'(RST_CYCLES - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = LOAD;
        end else if (st_q.busy) begin
            if (st_q.cnt == '0) st_d.busy = 1'b0;
            else                st_d.cnt  = st_q.cnt - 1'b1;
        end
    end

    // hardware reset leaves the sequence running so power-up behaves like a soft reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy <= 1'b1;
            st_q.cnt  <= LOAD;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
endmodule

// File: rtl/sidle_gate.sv
module sidle_gate (
    input  logic ack_i,
    input  logic bus_active_i,
    input  logic autoidle_i,
    input  logic clkact_i,
    input  logic wake_en_i,
    output logic clk_en_o,
    output logic wakeup_o
);
    logic run_d, idle_cut_d;

    always_comb begin
        run_d      = autoidle_i ? bus_active_i : 1'b1;
        idle_cut_d = ack_i & ~clkact_i;
        clk_en_o   = run_d & ~idle_cut_d;
        wakeup_o   = wake_en_i & ack_i & bus_active_i;
    end
endmodule

// File: rtl/slave_idle_ctrl.sv
module slave_idle_ctrl
    import sidle_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idle_req_i,
    input  logic       bus_active_i,
    input  logic [1:0] idle_mode_i,
    input  logic       autoidle_i,
    input  logic       clkact_i,
    input  logic       wake_en_i,
    input  logic       srst_wr_i,
    input  logic       srst_data_i,
    output logic       idle_ack_o,
    output logic       clk_en_o,
    output logic       wakeup_o,
    output logic       int_rst_o,
    output logic       reset_done_o
);
    logic ack_w, busy_w, start_w;

    assign start_w = srst_wr_i & srst_data_i;

    sidle_ack_fsm u_ack (
        .clk          (clk),
        .rst_n        (rst_n),
        .idle_req_i   (idle_req_i),
        .bus_active_i (bus_active_i),
        .mode_i       (idle_mode_e'(idle_mode_i)),
        .ack_o        (ack_w)
    );

    sidle_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_w),
        .busy_o  (busy_w)
    );

    sidle_gate u_gate (
        .ack_i        (ack_w),
        .bus_active_i (bus_active_i),
        .autoidle_i   (autoidle_i),
        .clkact_i     (clkact_i),
        .wake_en_i    (wake_en_i),
        .clk_en_o     (clk_en_o),
        .wakeup_o     (wakeup_o)
    );

    assign idle_ack_o   = ack_w;
    assign int_rst_o    = busy_w;
    assign reset_done_o = ~busy_w;
endmodule

// File: rtl/sidle_ctrl_chk.sv
module sidle_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       idle_req_i,
    input logic       bus_active_i,
    input logic [1:0] idle_mode_i,
    input logic       clkact_i,
    input logic       wake_en_i,
    input logic       srst_wr_i,
    input logic       srst_data_i,
    input logic       idle_ack_o,
    input logic       clk_en_o,
    input logic       wakeup_o,
    input logic       int_rst_o,
    input logic       reset_done_o
);
    p_force_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_req_i && (idle_mode_i == 2'd0 || idle_mode_i == 2'd3)) |=> idle_ack_o);

    p_never_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_mode_i == 2'd1) |=> !idle_ack_o);

    p_smart_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_req_i && idle_mode_i == 2'd2 && !idle_ack_o && bus_active_i) |=> !idle_ack_o);

    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_req_i |=> !idle_ack_o);

    p_seq_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (srst_wr_i && srst_data_i) |=> (int_rst_o && !reset_done_o));

    p_done_inverse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int_rst_o != reset_done_o);

    p_idle_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_ack_o && !clkact_i) |-> !clk_en_o);

    p_wake_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wakeup_o |-> (wake_en_i && idle_ack_o));
endmodule

bind slave_idle_ctrl sidle_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .idle_req_i   (idle_req_i),
    .bus_active_i (bus_active_i),
    .idle_mode_i  (idle_mode_i),
    .clkact_i     (clkact_i),
    .wake_en_i    (wake_en_i),
    .srst_wr_i    (srst_wr_i),
    .srst_data_i  (srst_data_i),
    .idle_ack_o   (idle_ack_o),
    .clk_en_o     (clk_en_o),
    .wakeup_o     (wakeup_o),
    .int_rst_o    (int_rst_o),
    .reset_done_o (reset_done_o)
);

// File: tb/slave_idle_ctrl_tb.sv
module slave_idle_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SEQ_LEN    = 16;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0, act = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       aidle = 1'b0, cact = 1'b1, wen = 1'b0;
    logic       swr = 1'b0, sdat = 1'b0;
    logic       ack, clk_en, wake, irst, done;

    int errors = 0, checks = 0;
    bit finished = 0;
    string rst_tag = "R7";

    // bench model state
    logic m_ack = 1'b0;
    logic m_busy = 1'b1;
    int   m_cnt = SEQ_LEN - 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    slave_idle_ctrl #(.RST_CYCLES(SEQ_LEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .idle_req_i(req), .bus_active_i(act),
        .idle_mode_i(mode), .autoidle_i(aidle), .clkact_i(cact), .wake_en_i(wen),
        .srst_wr_i(swr), .srst_data_i(sdat), .idle_ack_o(ack), .clk_en_o(clk_en),
        .wakeup_o(wake), .int_rst_o(irst), .reset_done_o(done)
    );

    function automatic logic exp_ack(logic q, logic r, logic [1:0] md, logic a);
        if (!r) return 1'b0;
        case (md)
            2'd1:    return 1'b0;
            2'd2:    return q | ~a;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic exp_clk_en(logic k, logic a, logic ai, logic ca);
        if (k && !ca) return 1'b0;
        return ai ? a : 1'b1;
    endfunction

    function automatic logic exp_wake(logic k, logic a, logic we);
        return we & k & a;
    endfunction

    task automatic chk(string tag, string what, logic got, logic want);
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s %s: got %b expected %b at %0t", tag, what, got, want, $time);
        end
    endtask

    task automatic check_all();
        string atag;
        if (!req)           atag = "R4";
        else if (mode == 1) atag = "R2";
        else if (mode == 2) atag = "R3";
        else                atag = "R1";
        // ack reflects inputs of the previous edge; tag by current view is only a label
        chk(atag, "idle_ack", ack, m_ack);
        chk(rst_tag, "int_rst", irst, m_busy);
        chk(rst_tag, "reset_done", done, ~m_busy);
        chk((m_ack && !cact) ? "R9" : "R8", "clk_en", clk_en, exp_clk_en(m_ack, act, aidle, cact));
        chk("R10", "wakeup", wake, exp_wake(m_ack, act, wen));
    endtask

    // inputs already set (after a negedge); check, then advance one edge
    task automatic step();
        #1 check_all();
        @(posedge clk);
        m_ack = exp_ack(m_ack, req, mode, act);
        if (swr && sdat) begin
            m_busy = 1'b1; m_cnt = SEQ_LEN - 1;
        end else if (m_busy) begin
            if (m_cnt == 0) m_busy = 1'b0;
            else m_cnt--;
        end
        @(negedge clk);
        swr = 1'b0; sdat = 1'b0;
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R7 reset state while held in reset
        chk("R7", "int_rst in reset", irst, 1'b1);
        chk("R7", "reset_done in reset", done, 1'b0);
        chk("R1", "idle_ack in reset", ack, 1'b0);
        rst_n = 1'b1;
        rst_tag = "R7";
        for (int i = 0; i < SEQ_LEN + 2; i++) step();
        chk("R7", "done after power-up sequence", done, 1'b1);

        // R5 zero-data write has no effect
        rst_tag = "R5";
        swr = 1'b1; sdat = 1'b0; step();
        chk("R5", "zero write keeps done", done, 1'b1);

        // R5 full sequence length
        swr = 1'b1; sdat = 1'b1; step();
        for (int i = 0; i < SEQ_LEN + 1; i++) step();

        // R6 restart mid-sequence
        rst_tag = "R6";
        swr = 1'b1; sdat = 1'b1; step();
        for (int i = 0; i < 7; i++) step();
        swr = 1'b1; sdat = 1'b1; step();
        for (int i = 0; i < SEQ_LEN + 1; i++) step();
        rst_tag = "R5";

        // R3 directed: smart waits for quiet bus
        mode = 2'd2; req = 1'b1; act = 1'b1; cact = 1'b0; wen = 1'b1;
        for (int i = 0; i < 4; i++) step();
        act = 1'b0; step();
        act = 1'b1; for (int i = 0; i < 3; i++) step();   // sticky, R10 wakeup high
        req = 1'b0; step(); step();                        // R4
        // R1 directed: spare code acts as force with busy bus
        mode = 2'd3; req = 1'b1; act = 1'b1; step(); step();
        req = 1'b0; step();

        // random phase
        for (int i = 0; i < 3000; i++) begin
            if ($urandom % 8 == 0)  req   = ~req;
            if ($urandom % 16 == 0) mode  = 2'($urandom % 4);
            act   = 1'($urandom % 2);
            if ($urandom % 10 == 0) aidle = ~aidle;
            if ($urandom % 10 == 0) cact  = ~cact;
            if ($urandom % 10 == 0) wen   = ~wen;
            if ($urandom % 40 == 0) begin swr = 1'b1; sdat = 1'($urandom % 2); end
            step();
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule